// File: doc/BRIEF.md
# DMA Stream Event Flag Bank

This block keeps the event flags of a DMA controller that runs eight streams. Each stream engine reports events with single-cycle set pulses: transfer done, half-way point, bus transfer error, direct-mode error and FIFO error. The block latches each pulse into a sticky flag. Software sees the flags through two read-only status words. The lower word holds streams 0 to 3 and the upper word holds streams 4 to 7. Software clears flags by writing ones to one of two clear addresses.

Each stream also drives one interrupt line. The line is high while any of that stream's flags is set and that flag's enable bit is also set. Flags, interrupt lines and read data are all registered, so every output comes straight from a flip-flop.

The register port is a plain one-cycle interface: address, write strobe, write data and registered read data. Any bus protocol adapter sits outside this block.

Top module: `dmaflag_bank`

## Requirements
- R1: While reset is high and on the first cycle after it, every flag is zero, every `irq` bit is zero and `reg_rdata` is zero.
- R2: A one on `set_pulse[s*5+b]` at a clock edge sets flag b of stream s at that edge, and the flag stays set until it is cleared. Flag codes are b=0 transfer done, b=1 half transfer, b=2 transfer error, b=3 direct-mode error and b=4 FIFO error.
- R3: Address 0 is the low status word and holds streams 0 to 3. Address 1 is the high status word and holds streams 4 to 7. Within each word, local stream k (0 to 3) has its 6-bit field at bit shift 0, 6, 16 and 22 respectively. Field bit b is flag b, and field bit 5 is always zero.
- R4: Writing to address 2 clears the flags of streams 0 to 3, and writing to address 3 clears those of streams 4 to 7. Each flag is cleared whose bit is one at its R3 position in `reg_wdata`. Zero bits leave their flags unchanged.
- R5: When a set pulse and a clearing write hit the same flag at the same edge, the flag is set after that edge.
- R6: Writes to addresses 0 and 1 change no flag.
- R7: `irq[s]` is registered and equals the OR over b of (flag b of stream s AND `irq_en[s*5+b]`). It updates at the same edge as the flags.
- R8: Every bit of a status word outside the 5 flag bits of its four fields reads as zero, and addresses 2 and 3 read as zero.
- R9: `reg_rdata` at an edge takes the value of the word addressed before that edge, using the flag values held before that edge. This gives one cycle of read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_pulse | input | 40 | Set pulses, 5 per stream, stream s at bits s*5 upward |
| irq_en | input | 40 | Interrupt enable per flag, same layout as set_pulse |
| reg_addr | input | 2 | Register select: 0/1 status low/high, 2/3 clear low/high |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data, ones mark flags to clear |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 8 | Per-stream interrupt lines |

## Verification
The hardest case to reach is a clearing write that lands in the same cycle as a set pulse on the very same flag. Random pulses and writes seldom line up on one flag, so directed steps drive all-ones clear words against full set vectors at the same edge. A reference model follows every cycle of a long random run with sparse pulses, mixed addresses and changing enables. The model compares read data and interrupt lines on every cycle, which also covers status writes and zero-bit writes that must leave the flags unchanged.

// File: rtl/dmaflag_pkg.sv
package dmaflag_pkg;
  localparam int NUM_STREAMS = 8;
  localparam int FLAGS_PER   = 5;
  localparam int FIELD_W     = 6;
  localparam int HALF_W      = 16;
  localparam int REG_W       = 32;

  typedef enum logic [1:0] {
    SEL_STAT_LO = 2'd0,
    SEL_STAT_HI = 2'd1,
    SEL_CLR_LO  = 2'd2,
    SEL_CLR_HI  = 2'd3
  } reg_sel_e;

  // Bit shift of a stream field inside its word: 0, 6, 16, 22 for k = 0..3.
  function automatic int field_shift(input int k, input int fw, input int hw);
    return (k % 2) * fw + (k / 2) * hw;
  endfunction
endpackage

// File: rtl/dmaflag_cell.sv
module dmaflag_cell #(
  parameter int NF = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  input  logic [NF-1:0] en_i,
  output logic [NF-1:0] flags_o,
  output logic          irq_o
);
  logic [NF-1:0] nxt;

  // Set has priority over a same-cycle clear.
  always_comb nxt = (flags_o & ~clr_i) | set_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      flags_o <= nxt;
      irq_o   <= |(nxt & en_i);
    end
  end

  assert_set_sticks_R2: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));

  assert_clear_effect_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_i != '0) |=> ((flags_o & $past(clr_i) & ~$past(set_i)) == '0));

  assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (rst)
    ((set_i & clr_i) != '0) |=> ((flags_o & $past(set_i & clr_i)) != '0));

  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (flags_o != '0));
endmodule

// File: rtl/dmaflag_rdport.sv
module dmaflag_rdport
  import dmaflag_pkg::*;
#(
  parameter int NS = 8,
  parameter int NF = 5,
  parameter int FW = 6,
  parameter int HW = 16,
  parameter int RW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       addr_i,
  input  logic [NS*NF-1:0] flags_i,
  output logic [RW-1:0]    rdata_o
);
  localparam int PER_REG = NS / 2;

  logic [RW-1:0] word_lo, word_hi, valid_mask;

  always_comb begin
    word_lo    = '0;
    word_hi    = '0;
    valid_mask = '0;
    for (int k = 0; k < PER_REG; k++) begin
      word_lo[field_shift(k, FW, HW) +: NF]    = flags_i[k*NF +: NF];
      word_hi[field_shift(k, FW, HW) +: NF]    = flags_i[(k+PER_REG)*NF +: NF];
      valid_mask[field_shift(k, FW, HW) +: NF] = '1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else begin
      case (reg_sel_e'(addr_i))
        SEL_STAT_LO: rdata_o <= word_lo;
        SEL_STAT_HI: rdata_o <= word_hi;
        default:     rdata_o <= '0;
      endcase
    end
  end

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rdata_o & ~valid_mask) == '0);

  assert_clear_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
    addr_i[1] |=> (rdata_o == '0));
endmodule

// File: rtl/dmaflag_bank.sv
module dmaflag_bank
  import dmaflag_pkg::*;
#(
  parameter int NUM_S = NUM_STREAMS,
  parameter int NF    = FLAGS_PER,
  parameter int FW    = FIELD_W,
  parameter int HW    = HALF_W,
  parameter int RW    = REG_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_S*NF-1:0] set_pulse,
  input  logic [NUM_S*NF-1:0] irq_en,
  input  logic [1:0]          reg_addr,
  input  logic                reg_wr,
  input  logic [RW-1:0]       reg_wdata,
  output logic [RW-1:0]       reg_rdata,
  output logic [NUM_S-1:0]    irq
);
  localparam int PER_REG = NUM_S / 2;

  logic [NUM_S*NF-1:0] flag_vec;
  logic [NUM_S*NF-1:0] clr_vec;
  logic                clr_lo, clr_hi;

  always_comb begin
    clr_lo = reg_wr && (reg_sel_e'(reg_addr) == SEL_CLR_LO);
    clr_hi = reg_wr && (reg_sel_e'(reg_addr) == SEL_CLR_HI);
  end

  for (genvar s = 0; s < NUM_S; s++) begin : g_stream
    localparam int LOCAL = s % PER_REG;
    localparam int SH    = field_shift(LOCAL, FW, HW);
    localparam bit HIGH  = (s >= PER_REG);

    logic hit;
    always_comb hit = HIGH ? clr_hi : clr_lo;
    assign clr_vec[s*NF +: NF] = hit ? reg_wdata[SH +: NF] : '0;

    dmaflag_cell #(.NF(NF)) u_cell (
      .clk     (clk),
      .rst     (rst),
      .set_i   (set_pulse[s*NF +: NF]),
      .clr_i   (clr_vec[s*NF +: NF]),
      .en_i    (irq_en[s*NF +: NF]),
      .flags_o (flag_vec[s*NF +: NF]),
      .irq_o   (irq[s])
    );
  end

  dmaflag_rdport #(.NS(NUM_S), .NF(NF), .FW(FW), .HW(HW), .RW(RW)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (reg_addr),
    .flags_i (flag_vec),
    .rdata_o (reg_rdata)
  );

  assert_status_write_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_addr[1] && set_pulse == '0) |=> $stable(flag_vec));

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (!reg_wr && set_pulse == '0) |=> $stable(flag_vec));

  assert_reset_clean_R1: assert property (@(posedge clk)
    $past(rst) |-> (flag_vec == '0 && irq == '0 && reg_rdata == '0));
endmodule

// File: tb/dmaflag_bank_test.sv
`timescale 1ns/1ps
module dmaflag_bank_test;
  localparam int NS = 8;
  localparam int NF = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [39:0]   set_pulse = '0;
  logic [39:0]   irq_en = '0;
  logic [1:0]    reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [7:0]    irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [4:0] model [NS];

  always #2 clk = ~clk;

  dmaflag_bank uut (
    .clk(clk), .rst(rst), .set_pulse(set_pulse), .irq_en(irq_en),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic int shift_of(input int k);
    case (k)
      0: return 0;
      1: return 6;
      2: return 16;
      default: return 22;
    endcase
  endfunction

  function automatic logic [31:0] word_of(input logic [1:0] a);
    logic [31:0] w = '0;
    if (a < 2) for (int k = 0; k < 4; k++)
      w[shift_of(k) +: 5] = model[k + 4*a];
    return w;
  endfunction

  function automatic logic [7:0] irq_of();
    logic [7:0] r;
    for (int s = 0; s < NS; s++) r[s] = |(model[s] & irq_en[s*5 +: 5]);
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [1:0] a, input logic wr,
                      input logic [31:0] wd, input logic [39:0] sp);
    logic [31:0] exp_rd;
    @(negedge clk);
    reg_addr = a; reg_wr = wr; reg_wdata = wd; set_pulse = sp;
    @(posedge clk);
    exp_rd = word_of(a);
    for (int s = 0; s < NS; s++) begin
      logic [4:0] c = '0;
      if (wr && a == 2'd2 && s < 4) c = wd[shift_of(s) +: 5];
      if (wr && a == 2'd3 && s >= 4) c = wd[shift_of(s-4) +: 5];
      model[s] = (model[s] & ~c) | sp[s*5 +: 5];
    end
    #1;
    check({tag, " rdata"}, reg_rdata, exp_rd);
    check({tag, " irq"}, {24'd0, irq}, {24'd0, irq_of()});
  endtask

  initial begin
    #(200000*4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int s = 0; s < NS; s++) model[s] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check("R1 rdata", reg_rdata, 32'd0);
    check("R1 irq", {24'd0, irq}, 32'd0);
    step("R1", 2'd0, 1'b0, '0, '0);
    step("R1", 2'd1, 1'b0, '0, '0);

    // R2/R3: one flag per stream at distinct codes, then read both words.
    irq_en = '1;
    for (int s = 0; s < NS; s++) begin
      logic [39:0] p = '0;
      p[s*5 + (s % 5)] = 1'b1;
      step("R2", 2'd0, 1'b0, '0, p);
    end
    step("R3", 2'd0, 1'b0, '0, '0);
    step("R3", 2'd1, 1'b0, '0, '0);
    step("R9", 2'd0, 1'b0, '0, '0);

    // R8: everything set, reserved bits and clear addresses read zero.
    step("R8", 2'd0, 1'b0, '0, '1);
    step("R8", 2'd1, 1'b0, '0, '0);
    step("R8", 2'd0, 1'b0, '0, '0);
    check("R8 low mask", reg_rdata, 32'h07DF_07DF & 32'h07DF_07DF);
    step("R8", 2'd2, 1'b0, '0, '0);
    check("R8 clear addr", reg_rdata, 32'd0);

    // R6: status writes of all ones change nothing.
    step("R6", 2'd0, 1'b1, 32'hFFFF_FFFF, '0);
    step("R6", 2'd1, 1'b1, 32'hFFFF_FFFF, '0);
    step("R6", 2'd0, 1'b0, '0, '0);
    step("R6", 2'd1, 1'b0, '0, '0);

    // R4: zero bits leave flags; selective clear of stream 1 and 6.
    step("R4", 2'd2, 1'b1, 32'd0, '0);
    step("R4", 2'd2, 1'b1, 32'h0000_0040, '0);
    step("R4", 2'd3, 1'b1, 32'h001F_0000, '0);
    step("R4", 2'd0, 1'b0, '0, '0);
    step("R4", 2'd1, 1'b0, '0, '0);

    // R5: clear-all against set-all on the same edge.
    step("R5", 2'd2, 1'b1, 32'hFFFF_FFFF, '1);
    step("R5", 2'd3, 1'b1, 32'hFFFF_FFFF, '1);
    step("R5", 2'd0, 1'b0, '0, '0);
    step("R5", 2'd1, 1'b0, '0, '0);

    // R7: enable gating, clear everything then set masked flags.
    step("R7", 2'd2, 1'b1, 32'hFFFF_FFFF, '0);
    step("R7", 2'd3, 1'b1, 32'hFFFF_FFFF, '0);
    irq_en = 40'h00_0000_0001;
    step("R7", 2'd0, 1'b0, '0, 40'h00_0000_0002);
    step("R7", 2'd0, 1'b0, '0, 40'h00_0000_0001);

    // Random mix against the model.
    for (int i = 0; i < 600; i++) begin
      logic [39:0] sp = '0;
      logic [1:0]  a = 2'($urandom_range(0, 3));
      logic        wr = ($urandom_range(0, 2) == 0);
      if (i % 50 == 0) irq_en = {8'($urandom), $urandom};
      for (int b = 0; b < 40; b++) sp[b] = ($urandom_range(0, 15) == 0);
      step("R2 R4 R7 R9 random", a, wr, $urandom, sp);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule